// File: doc/BRIEF.md
# Single-Wire Debug Target Bit Engine

This block sits on the target side of a bidirectional single-wire debug pin and runs on the target's debug clock. The host begins every bit by pulling the wire low. The engine passes the wire through a two-stage synchronizer and detects the falling edge. It then takes that edge as the start of a bit time and times the rest of the bit against it.

In receive mode the engine only listens. It samples the wire a fixed number of cycles into the bit and reports the level with a one-cycle strobe. In transmit mode the engine completes a bit the host has started. To send a zero, it holds the wire low and then gives one cycle of active-high drive to sharpen the rising edge. To send a one, it leaves the wire alone except for a single active-high speedup pulse. A bit window of fixed length follows each accepted start, and falling edges inside that window are discarded. Byte framing and command decoding belong to the blocks that surround this one.

Top module: `sdbg_target_bit_engine`

## Requirements
- R1: After reset, `pin_oe`, `busy` and `rx_valid` are all 0.
- R2: A falling edge on `pin_in` passes through a two-flop synchronizer and an edge compare. If the wire goes low just after a clock edge E, `busy` is 1 from the third clock edge after E onward. Bit cycle k=0 is the first cycle with `busy` high, and all later offsets count from it.
- R3: `busy` stays high for exactly 16 cycles (k=0..15). A falling edge that arrives while `busy` is high does not start a bit, does not produce a strobe and does not extend the window.
- R4: In receive mode (`dir_tx`=0), `rx_valid` is high for exactly one cycle, at k=10. At that time `rx_bit` holds the wire level as the synchronizer saw it. A host that holds the wire low through the sample point gives 0, and a host that releases after 3 cycles gives 1.
- R5: In receive mode, `pin_oe` stays 0 for the whole bit.
- R6: To send a 0 (`tx_bit`=0), the engine drives `pin_oe`=1 with `pin_out`=0 for k=0..12. It drives `pin_oe`=1 with `pin_out`=1 for k=13 only, and sets `pin_oe`=0 from k=14 onward.
- R7: To send a 1 (`tx_bit`=1), the engine drives `pin_oe`=1 with `pin_out`=1 at k=7 only, and `pin_oe`=0 at every other cycle.
- R8: `dir_tx` and `tx_bit` are captured at the bit start. Changing them during the bit has no effect on `pin_oe`, `pin_out` or `rx_valid`.
- R9: In transmit mode `rx_valid` never rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Target debug clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 1 | Level on the debug wire (asynchronous) |
| dir_tx | input | 1 | Mode for the next bit: 1 = target transmits, 0 = target receives |
| tx_bit | input | 1 | Bit value to send when transmitting |
| pin_out | output | 1 | Level the target drives onto the wire |
| pin_oe | output | 1 | Drive enable for the wire; 0 = high impedance |
| rx_bit | output | 1 | Received bit value |
| rx_valid | output | 1 | One-cycle strobe marking `rx_bit` as new |
| busy | output | 1 | A bit window is in progress |

## Verification
The bench runs received ones, received zeros, transmitted zeros and transmitted ones. The received cases show that the sample point falls inside the host's hold time for a zero and after its release for a one. The transmitted cases show that the low phase and the pulse land on the right cycles and that the drive enable lets go straight after the pulse. One received bit carries a second host low pulse inside its window, which checks that mid-window edges are discarded. Another received bit flips the mode and the data inputs partway through, which shows that both are captured only at the bit start.

// File: rtl/sdbg_pkg.sv
package sdbg_pkg;

    localparam int unsigned WINDOW_LEN   = 16;
    localparam int unsigned SAMPLE_AT    = 10;
    localparam int unsigned ZERO_LOW_LEN = 13;
    localparam int unsigned ONE_PULSE_AT = 7;
    localparam int unsigned CNT_W        = $clog2(WINDOW_LEN);

    typedef logic [CNT_W-1:0] bit_cnt_t;

    typedef enum logic {
        MODE_RX = 1'b0,
        MODE_TX = 1'b1
    } bit_mode_e;

    typedef struct packed {
        bit_mode_e mode;
        logic      txb;
    } bit_ctx_t;

    typedef struct packed {
        logic oe;
        logic out;
    } pin_drv_t;

    localparam pin_drv_t DRV_HIZ  = '{oe: 1'b0, out: 1'b0};
    localparam pin_drv_t DRV_LOW  = '{oe: 1'b1, out: 1'b0};
    localparam pin_drv_t DRV_HIGH = '{oe: 1'b1, out: 1'b1};

    function automatic bit_cnt_t to_cnt(input int unsigned v);
        return bit_cnt_t'(v);
    endfunction

endpackage

// File: rtl/sdbg_edge_sync.sv
module sdbg_edge_sync (
    input  logic clk,
    input  logic rst,
    input  logic pin_i,
    output logic level_o,
    output logic fall_o
);
    logic sync1_q, sync2_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1_q <= 1'b1;
            sync2_q <= 1'b1;
            prev_q  <= 1'b1;
        end else begin
            sync1_q <= pin_i;
            sync2_q <= sync1_q;
            prev_q  <= sync2_q;
        end
    end

    assign level_o = sync2_q;
    assign fall_o  = prev_q & ~sync2_q;

    AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (rst)
        fall_o |=> !fall_o); // R2

endmodule

// File: rtl/sdbg_bit_timer.sv
module sdbg_bit_timer
    import sdbg_pkg::*;
#(
    parameter int unsigned WIN = WINDOW_LEN
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     fall_i,
    input  bit_ctx_t ctx_i,
    output logic     busy_o,
    output bit_cnt_t cnt_o,
    output bit_ctx_t ctx_o
);
    localparam bit_cnt_t LAST = to_cnt(WIN - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_o <= 1'b0;
            cnt_o  <= '0;
            ctx_o  <= '{mode: MODE_RX, txb: 1'b0};
        end else if (!busy_o) begin
            if (fall_i) begin
                busy_o <= 1'b1;
                cnt_o  <= '0;
                ctx_o  <= ctx_i;
            end
        end else if (cnt_o == LAST) begin
            busy_o <= 1'b0;
            cnt_o  <= '0;
        end else begin
            cnt_o  <= cnt_o + 1'b1;
        end
    end

    AST_START_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> cnt_o == '0); // R2
    AST_WINDOW_LEN: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> $past(cnt_o) == LAST); // R3
    AST_CTX_HELD: assert property (@(posedge clk) disable iff (rst)
        busy_o && $past(busy_o) |-> $stable(ctx_o)); // R8

endmodule

// File: rtl/sdbg_tx_shaper.sv
module sdbg_tx_shaper
    import sdbg_pkg::*;
#(
    parameter int unsigned LOW_LEN  = ZERO_LOW_LEN,
    parameter int unsigned PULSE_AT = ONE_PULSE_AT
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     busy_i,
    input  bit_cnt_t cnt_i,
    input  bit_ctx_t ctx_i,
    output pin_drv_t drv_o
);
    localparam bit_cnt_t LOW_END = to_cnt(LOW_LEN);
    localparam bit_cnt_t ONE_PT  = to_cnt(PULSE_AT);

    always_comb begin
        drv_o = DRV_HIZ;
        if (busy_i && ctx_i.mode == MODE_TX) begin
            if (!ctx_i.txb) begin
                if (cnt_i < LOW_END)       drv_o = DRV_LOW;
                else if (cnt_i == LOW_END) drv_o = DRV_HIGH;
            end else if (cnt_i == ONE_PT) begin
                drv_o = DRV_HIGH;
            end
        end
    end

    AST_RX_QUIET: assert property (@(posedge clk) disable iff (rst)
        ctx_i.mode == MODE_RX |-> !drv_o.oe); // R5
    AST_PULSE_SHORT: assert property (@(posedge clk) disable iff (rst)
        drv_o.oe && drv_o.out |=> !drv_o.oe); // R6
    AST_LOW_ONLY_ZERO: assert property (@(posedge clk) disable iff (rst)
        drv_o.oe && !drv_o.out |-> !ctx_i.txb); // R7

endmodule

// File: rtl/sdbg_rx_sampler.sv
module sdbg_rx_sampler
    import sdbg_pkg::*;
#(
    parameter int unsigned AT = SAMPLE_AT
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     busy_i,
    input  bit_cnt_t cnt_i,
    input  bit_ctx_t ctx_i,
    input  logic     level_i,
    output logic     rx_bit_o,
    output logic     rx_valid_o
);
    localparam bit_cnt_t PRE = to_cnt(AT - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_bit_o   <= 1'b0;
            rx_valid_o <= 1'b0;
        end else begin
            rx_valid_o <= 1'b0;
            if (busy_i && ctx_i.mode == MODE_RX && cnt_i == PRE) begin
                rx_bit_o   <= level_i;
                rx_valid_o <= 1'b1;
            end
        end
    end

    AST_VALID_ONE: assert property (@(posedge clk) disable iff (rst)
        rx_valid_o |=> !rx_valid_o); // R4
    AST_VALID_PLACE: assert property (@(posedge clk) disable iff (rst)
        rx_valid_o |-> busy_i && cnt_i == to_cnt(AT)); // R4
    AST_NO_VALID_TX: assert property (@(posedge clk) disable iff (rst)
        rx_valid_o |-> ctx_i.mode == MODE_RX); // R9

endmodule

// File: rtl/sdbg_target_bit_engine.sv
module sdbg_target_bit_engine
    import sdbg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic pin_in,
    input  logic dir_tx,
    input  logic tx_bit,
    output logic pin_out,
    output logic pin_oe,
    output logic rx_bit,
    output logic rx_valid,
    output logic busy
);
    logic     level, fall;
    bit_cnt_t cnt;
    bit_ctx_t ctx_in, ctx;
    pin_drv_t drv;

    assign ctx_in = '{mode: bit_mode_e'(dir_tx), txb: tx_bit};

    sdbg_edge_sync u_sync (
        .clk(clk), .rst(rst), .pin_i(pin_in),
        .level_o(level), .fall_o(fall)
    );

    sdbg_bit_timer #(.WIN(WINDOW_LEN)) u_timer (
        .clk(clk), .rst(rst), .fall_i(fall), .ctx_i(ctx_in),
        .busy_o(busy), .cnt_o(cnt), .ctx_o(ctx)
    );

    sdbg_tx_shaper #(.LOW_LEN(ZERO_LOW_LEN), .PULSE_AT(ONE_PULSE_AT)) u_tx (
        .clk(clk), .rst(rst), .busy_i(busy), .cnt_i(cnt), .ctx_i(ctx),
        .drv_o(drv)
    );

    sdbg_rx_sampler #(.AT(SAMPLE_AT)) u_rx (
        .clk(clk), .rst(rst), .busy_i(busy), .cnt_i(cnt), .ctx_i(ctx),
        .level_i(level), .rx_bit_o(rx_bit), .rx_valid_o(rx_valid)
    );

    assign pin_oe  = drv.oe;
    assign pin_out = drv.out;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !pin_oe && !rx_valid); // R3
    AST_STROBE_UNDRIVEN: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> !pin_oe); // R5

endmodule

// File: tb/sdbg_target_bit_engine_bench.sv
module sdbg_target_bit_engine_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic host_low = 1'b0;
    logic dir_tx = 1'b0;
    logic tx_bit = 1'b0;
    logic pin_in, pin_out, pin_oe, rx_bit, rx_valid, busy;

    int total = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        logic val;
        int   at;
    } rx_item_t;
    rx_item_t exp_q[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // wire model: host pulls low, target drives, otherwise pulled up
    assign pin_in = host_low ? 1'b0 : (pin_oe ? pin_out : 1'b1);

    sdbg_target_bit_engine u_sdbg_target_bit_engine (
        .clk(clk), .rst(rst), .pin_in(pin_in), .dir_tx(dir_tx),
        .tx_bit(tx_bit), .pin_out(pin_out), .pin_oe(pin_oe),
        .rx_bit(rx_bit), .rx_valid(rx_valid), .busy(busy)
    );

    task automatic check(input string req, input string what,
                         input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%b expected=%b (cycle %0d)",
                     req, what, act, exp, cyc);
        end
    endtask

    // monitor: pop expected received bits when the strobe appears
    always @(negedge clk) begin
        if (!rst && rx_valid) begin
            if (exp_q.size() == 0) begin
                total++; fails++;
                $display("FAIL R9/R3 unexpected rx_valid: actual=1 expected=0 (cycle %0d)", cyc);
            end else begin
                rx_item_t it;
                it = exp_q.pop_front();
                check("R4", "rx_bit", rx_bit, it.val);
                total++;
                if (cyc != it.at) begin
                    fails++;
                    $display("FAIL R4 strobe cycle: actual=%0d expected=%0d", cyc, it.at);
                end
            end
        end
    end

    // one host-started bit; k = t-3 is the bit cycle offset (R2)
    task automatic host_bit(input logic dir, input logic txb, input int hold,
                            input logic rx_exp, input int glitch_at, input int flip_at);
        @(negedge clk);
        dir_tx = dir; tx_bit = txb; host_low = 1'b1;
        for (int t = 1; t <= 22; t++) begin
            int k;
            logic eoe, eout;
            @(negedge clk);
            k = t - 3;
            eoe = 1'b0; eout = 1'b0;
            if (dir && k >= 0 && k <= 15) begin
                if (!txb) begin
                    if (k < 13) begin eoe = 1'b1; eout = 1'b0; end
                    else if (k == 13) begin eoe = 1'b1; eout = 1'b1; end
                end else if (k == 7) begin eoe = 1'b1; eout = 1'b1; end
            end
            check("R2/R3", "busy", busy, (k >= 0 && k <= 15));
            if (dir && !txb) check("R6", "pin_oe", pin_oe, eoe);
            else if (dir)    check("R7", "pin_oe", pin_oe, eoe);
            else if (flip_at > 0) check("R8", "pin_oe", pin_oe, eoe);
            else             check("R5", "pin_oe", pin_oe, eoe);
            if (eoe) check(dir && !txb ? "R6" : "R7", "pin_out", pin_out, eout);
            if (k == 0 && !dir) begin
                rx_item_t it;
                it.val = rx_exp;
                it.at  = cyc + 10;
                exp_q.push_back(it);
            end
            if (t == hold) host_low = 1'b0;
            if (glitch_at > 0 && t == glitch_at) host_low = 1'b1;
            if (glitch_at > 0 && t == glitch_at + 3) host_low = 1'b0;
            if (flip_at > 0 && t == flip_at) begin dir_tx = ~dir; tx_bit = ~txb; end
        end
        dir_tx = 1'b0; tx_bit = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "pin_oe", pin_oe, 1'b0);
        check("R1", "busy", busy, 1'b0);
        check("R1", "rx_valid", rx_valid, 1'b0);
        host_bit(1'b0, 1'b0, 3,  1'b1, 0, 0);   // R4 receive one
        host_bit(1'b0, 1'b0, 12, 1'b0, 0, 0);   // R4 receive zero
        host_bit(1'b1, 1'b0, 3,  1'b0, 0, 0);   // R6 send zero
        host_bit(1'b1, 1'b1, 3,  1'b0, 0, 0);   // R7 send one
        host_bit(1'b0, 1'b0, 3,  1'b1, 5, 0);   // R3 edge in window ignored
        host_bit(1'b0, 1'b0, 3,  1'b1, 0, 5);   // R8 mode flip mid-bit
        host_bit(1'b1, 1'b0, 3,  1'b0, 0, 6);   // R8 data flip mid-bit
        host_bit(1'b0, 1'b1, 12, 1'b0, 0, 0);   // R4 tx_bit ignored in rx
        repeat (5) @(negedge clk);
        total++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R4 missing strobes: actual=%0d expected=0", exp_q.size());
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule